// File: doc/BRIEF.md
# Paged Packet Buffer Queue Manager

This block keeps track of the buffer pages of an on-board packet memory for a simple Ethernet controller. Each page holds 2 KB, and a page is named by a one-byte page number. Page numbers are the tokens that move between four hardware byte queues. The free queue holds unused pages. The transmit queue holds pages waiting to be sent. The done queue holds one status byte per finished transmission. The receive queue holds pages that carry received frames. Every queue shows its occupancy count. A host write port pushes one byte into a queue, and a host read port pops one byte from a queue.

After reset the host loads every usable page into the free queue in ascending order. A configuration input sets the highest usable page. When the receive side asks for a page, the head of the free queue moves to the tail of the receive queue. When the transmit side finishes a frame, the head of the transmit queue is retired and its status byte is appended to the done queue. If a page is requested while the free queue is empty, the receiver turns itself off and reports this on a sticky flag. Only the host can clear that flag.

Top module: `pbuf_page_mgr`

## Requirements
- R1: During and right after the synchronous active-high reset, every count is 0, `rx_not_empty`, `done_not_empty`, `tx_pending` and `rx_disabled` are 0, and `tx_head` is 0.
- R2: Queue select codes are 0 = free, 1 = transmit, 2 = done and 3 = receive. Every queue is first-in first-out. The count rises by one on an accepted push, falls by one on an accepted pop, and does not change when both happen in the same cycle.
- R3: Each queue holds 128 entries. A push to a full queue is ignored and the count stays at 128. A pop from an empty queue is ignored, the count stays at 0, and `host_rd_data` reads 0.
- R4: `last_page` is 63 when `mem_large` is 0 and 127 when it is 1. A host push to the free queue of page 0, or of a page above `last_page`, is ignored.
- R5: A `rx_req` pulse, while the receiver is enabled, the free queue is not empty and the receive queue is not full, moves the free-queue head to the tail of the receive queue. The counts show the move after the next clock edge.
- R6: `rx_not_empty` is 1 exactly when the receive-queue count is nonzero.
- R7: A `rx_req` while the receiver is enabled and the free queue is empty sets `rx_disabled`. The flag stays set until the host pulses `rxd_clr`. While it is set, `rx_req` moves no page.
- R8: A host push to select 1 queues a transmit page, and `tx_head` and `tx_pending` show the oldest one. `tx_complete` retires that page and appends `tx_status` unchanged to the done queue. `tx_complete` is ignored when the transmit queue is empty. `done_not_empty` is 1 exactly when the done count is nonzero.
- R9: `host_rd_data` is combinational and shows the head of the selected queue during a cycle with `host_rd_en`. It is always 0 for select 1. Host writes to selects 2 and 3 are ignored. When a receive allocation and a host free-queue read fall in the same cycle, the allocation takes the page, the host read returns 0, and only one page leaves the free queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_large | input | 1 | Memory-size configuration: 1 selects the larger page range |
| last_page | output | 8 | Highest usable page number |
| host_wr_en | input | 1 | Host push strobe |
| host_wr_sel | input | 2 | Queue selected for the push |
| host_wr_data | input | 8 | Byte to push |
| host_rd_en | input | 1 | Host pop strobe |
| host_rd_sel | input | 2 | Queue selected for the pop |
| host_rd_data | output | 8 | Popped byte, or 0 |
| free_count | output | 8 | Free queue occupancy |
| xmit_count | output | 8 | Transmit queue occupancy |
| done_count | output | 8 | Done queue occupancy |
| recv_count | output | 8 | Receive queue occupancy |
| rx_req | input | 1 | Receive side requests a page for a frame |
| rxd_clr | input | 1 | Host re-enables the receiver |
| rx_disabled | output | 1 | Sticky receiver-off flag |
| rx_not_empty | output | 1 | Receive queue holds a page |
| tx_head | output | 8 | Oldest queued transmit page, or 0 |
| tx_pending | output | 1 | Transmit queue holds a page |
| tx_complete | input | 1 | Transmit side finished the head page |
| tx_status | input | 8 | Completion status byte for the done queue |
| done_not_empty | output | 1 | Done queue holds a status byte |

## Verification
The bench builds the block with its default parameters: a depth of 128, one-byte pages, and last pages of 63 and 127. With this depth, the transmit queue can be pushed past 128 entries, because its pages are not range-filtered, so the full-queue case is reached there. The done queue is filled to its limit by the matching completions. Both memory-size settings are driven, so the page filter is tested at 63, 64, 127 and 128. Draining the free queue with host reads reaches the receiver-off path.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
   typedef enum logic [1:0] {
      Q_FREE = 2'd0,
      Q_XMIT = 2'd1,
      Q_DONE = 2'd2,
      Q_RECV = 2'd3
   } qsel_e;
   localparam int NUM_Q = 4;
endpackage

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 128,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pbuf_fifo: DEPTH must be at least 2");
   end
   if ((1 << CW) <= DEPTH) begin : g_bad_cw
      $error("pbuf_fifo: CW too narrow for DEPTH");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          full, push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == DEPTH_C);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = empty ? '0 : mem[rd_ptr];

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_mod
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      count <= DEPTH_C); // R2
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
      (empty && pop && !push) |=> (count == '0)); // R3
   AST_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
      (full && push && !pop) |=> (count == DEPTH_C)); // R3
endmodule

// File: rtl/pbuf_page_limit.sv
module pbuf_page_limit #(
   parameter int PW         = 8,
   parameter int SMALL_LAST = 63,
   parameter int LARGE_LAST = 127
) (
   input  logic          mem_large,
   input  logic [PW-1:0] page,
   output logic [PW-1:0] last_page,
   output logic          page_ok
);
   localparam logic [PW-1:0] SL = PW'(SMALL_LAST);
   localparam logic [PW-1:0] LL = PW'(LARGE_LAST);

   if (LARGE_LAST >= (1 << PW)) begin : g_bad_large
      $error("pbuf_page_limit: LARGE_LAST does not fit a page number");
   end
   if (SMALL_LAST < 1 || SMALL_LAST > LARGE_LAST) begin : g_bad_small
      $error("pbuf_page_limit: SMALL_LAST out of range");
   end

   assign last_page = mem_large ? LL : SL;
   assign page_ok   = (page != '0) && (page <= last_page);
endmodule

// File: rtl/pbuf_rx_ctl.sv
module pbuf_rx_ctl (
   input  logic clk,
   input  logic rst,
   input  logic rx_req,
   input  logic rxd_clr,
   input  logic free_empty,
   input  logic recv_full,
   output logic alloc,
   output logic rx_disabled
);
   logic starve;

   assign alloc  = rx_req && !rx_disabled && !free_empty && !recv_full;
   assign starve = rx_req && !rx_disabled && free_empty;

   always_ff @(posedge clk) begin
      if (rst)          rx_disabled <= 1'b0;
      else if (starve)  rx_disabled <= 1'b1;
      else if (rxd_clr) rx_disabled <= 1'b0;
   end

   AST_RXD_SET: assert property (@(posedge clk) disable iff (rst)
      (rx_req && !rx_disabled && free_empty) |=> rx_disabled); // R7
   AST_RXD_STICKY: assert property (@(posedge clk) disable iff (rst)
      (rx_disabled && !rxd_clr) |=> rx_disabled); // R7
endmodule

// File: rtl/pbuf_page_mgr.sv
module pbuf_page_mgr
   import pbuf_pkg::*;
#(
   parameter int PW         = 8,
   parameter int DEPTH      = 128,
   parameter int SMALL_LAST = 63,
   parameter int LARGE_LAST = 127,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mem_large,
   output logic [PW-1:0] last_page,
   input  logic          host_wr_en,
   input  logic [1:0]    host_wr_sel,
   input  logic [PW-1:0] host_wr_data,
   input  logic          host_rd_en,
   input  logic [1:0]    host_rd_sel,
   output logic [PW-1:0] host_rd_data,
   output logic [CW-1:0] free_count,
   output logic [CW-1:0] xmit_count,
   output logic [CW-1:0] done_count,
   output logic [CW-1:0] recv_count,
   input  logic          rx_req,
   input  logic          rxd_clr,
   output logic          rx_disabled,
   output logic          rx_not_empty,
   output logic [PW-1:0] tx_head,
   output logic          tx_pending,
   input  logic          tx_complete,
   input  logic [PW-1:0] tx_status,
   output logic          done_not_empty
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (LARGE_LAST >= DEPTH) begin : g_bad_fit
      $error("pbuf_page_mgr: queue depth must exceed the page count");
   end

   logic [NUM_Q-1:0] q_push, q_pop, q_empty;
   logic [PW-1:0]    q_din  [NUM_Q];
   logic [PW-1:0]    q_head [NUM_Q];
   logic [CW-1:0]    q_cnt  [NUM_Q];

   qsel_e wsel, rsel;
   logic  page_ok, alloc, recv_full;

   assign wsel = qsel_e'(host_wr_sel);
   assign rsel = qsel_e'(host_rd_sel);

   pbuf_page_limit #(
      .PW(PW), .SMALL_LAST(SMALL_LAST), .LARGE_LAST(LARGE_LAST)
   ) u_limit (
      .mem_large (mem_large),
      .page      (host_wr_data),
      .last_page (last_page),
      .page_ok   (page_ok)
   );

   assign recv_full = (q_cnt[Q_RECV] == DEPTH_C);

   pbuf_rx_ctl u_rx (
      .clk         (clk),
      .rst         (rst),
      .rx_req      (rx_req),
      .rxd_clr     (rxd_clr),
      .free_empty  (q_empty[Q_FREE]),
      .recv_full   (recv_full),
      .alloc       (alloc),
      .rx_disabled (rx_disabled)
   );

   always_comb begin
      q_push         = '0;
      q_pop          = '0;
      q_din[Q_FREE]  = host_wr_data;
      q_din[Q_XMIT]  = host_wr_data;
      q_din[Q_DONE]  = tx_status;
      q_din[Q_RECV]  = q_head[Q_FREE];

      q_push[Q_FREE] = host_wr_en && (wsel == Q_FREE) && page_ok;
      q_push[Q_XMIT] = host_wr_en && (wsel == Q_XMIT);
      q_push[Q_DONE] = tx_complete && !q_empty[Q_XMIT];
      q_push[Q_RECV] = alloc;

      q_pop[Q_FREE]  = alloc || (host_rd_en && (rsel == Q_FREE));
      q_pop[Q_XMIT]  = tx_complete;
      q_pop[Q_DONE]  = host_rd_en && (rsel == Q_DONE);
      q_pop[Q_RECV]  = host_rd_en && (rsel == Q_RECV);
   end

   for (genvar g = 0; g < NUM_Q; g++) begin : g_q
      pbuf_fifo #(.W(PW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
         .clk   (clk),
         .rst   (rst),
         .push  (q_push[g]),
         .din   (q_din[g]),
         .pop   (q_pop[g]),
         .head  (q_head[g]),
         .count (q_cnt[g]),
         .empty (q_empty[g])
      );
   end

   always_comb begin
      host_rd_data = '0;
      if (host_rd_en) begin
         case (rsel)
            Q_FREE:  host_rd_data = alloc ? '0 : q_head[Q_FREE];
            Q_DONE:  host_rd_data = q_head[Q_DONE];
            Q_RECV:  host_rd_data = q_head[Q_RECV];
            default: host_rd_data = '0;
         endcase
      end
   end

   assign free_count     = q_cnt[Q_FREE];
   assign xmit_count     = q_cnt[Q_XMIT];
   assign done_count     = q_cnt[Q_DONE];
   assign recv_count     = q_cnt[Q_RECV];
   assign tx_head        = q_head[Q_XMIT];
   assign tx_pending     = !q_empty[Q_XMIT];
   assign rx_not_empty   = !q_empty[Q_RECV];
   assign done_not_empty = !q_empty[Q_DONE];

   AST_RX_MOVE: assert property (@(posedge clk) disable iff (rst)
      alloc |=> (recv_count != '0)); // R5
   AST_FREE_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (free_count != '0) |-> (q_head[Q_FREE] != '0)); // R4
   AST_SHARED_POP: assert property (@(posedge clk) disable iff (rst)
      (alloc && host_rd_en && (rsel == Q_FREE) && !host_wr_en)
      |=> (free_count == $past(free_count) - 1'b1)); // R9
   AST_DONE_APPEND: assert property (@(posedge clk) disable iff (rst)
      (tx_complete && tx_pending && (done_count != DEPTH_C)
       && !(host_rd_en && (rsel == Q_DONE)))
      |=> (done_count == $past(done_count) + 1'b1)); // R8
endmodule

// File: tb/pbuf_page_mgr_test.sv
`timescale 1ns/1ps
module pbuf_page_mgr_test;
   localparam int DEPTH = 128;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mem_large = 1'b0;
   logic [7:0] last_page;
   logic       host_wr_en = 1'b0;
   logic [1:0] host_wr_sel = '0;
   logic [7:0] host_wr_data = '0;
   logic       host_rd_en = 1'b0;
   logic [1:0] host_rd_sel = '0;
   logic [7:0] host_rd_data;
   logic [7:0] free_count, xmit_count, done_count, recv_count;
   logic       rx_req = 1'b0;
   logic       rxd_clr = 1'b0;
   logic       rx_disabled, rx_not_empty, tx_pending, done_not_empty;
   logic [7:0] tx_head;
   logic       tx_complete = 1'b0;
   logic [7:0] tx_status = '0;

   int checks = 0;
   int fails  = 0;
   bit mon_on = 1'b0;

   logic [7:0] mfree[$], mtx[$], mdone[$], mrx[$];
   bit         m_rxd = 1'b0;

   always #4 clk = ~clk;

   pbuf_page_mgr uut (
      .clk(clk), .rst(rst), .mem_large(mem_large), .last_page(last_page),
      .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
      .free_count(free_count), .xmit_count(xmit_count), .done_count(done_count),
      .recv_count(recv_count), .rx_req(rx_req), .rxd_clr(rxd_clr),
      .rx_disabled(rx_disabled), .rx_not_empty(rx_not_empty), .tx_head(tx_head),
      .tx_pending(tx_pending), .tx_complete(tx_complete), .tx_status(tx_status),
      .done_not_empty(done_not_empty)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // monitor: compares registered state against the scoreboard model
   always @(negedge clk) begin
      if (mon_on) begin
         chk("R2 free_count", int'(free_count), mfree.size());
         chk("R2 xmit_count", int'(xmit_count), mtx.size());
         chk("R2 done_count", int'(done_count), mdone.size());
         chk("R5 recv_count", int'(recv_count), mrx.size());
         chk("R6 rx_not_empty", int'(rx_not_empty), int'(mrx.size() != 0));
         chk("R7 rx_disabled", int'(rx_disabled), int'(m_rxd));
         chk("R8 done_not_empty", int'(done_not_empty), int'(mdone.size() != 0));
      end
   end

   task automatic step(input bit we, input logic [1:0] ws, input logic [7:0] wd,
                       input bit re, input logic [1:0] rs, input bit rq,
                       input bit tc, input logic [7:0] ts, input bit clr,
                       input string tag);
      int sf, st, sd, sr, lastp;
      bit al, starve;
      int exp_rd;
      logic [7:0] fv;
      @(negedge clk);
      host_wr_en = we; host_wr_sel = ws; host_wr_data = wd;
      host_rd_en = re; host_rd_sel = rs; rx_req = rq;
      tx_complete = tc; tx_status = ts; rxd_clr = clr;
      #1;
      sf = mfree.size(); st = mtx.size(); sd = mdone.size(); sr = mrx.size();
      lastp = mem_large ? 127 : 63;
      al = rq && !m_rxd && sf > 0 && sr < DEPTH;
      starve = rq && !m_rxd && sf == 0;
      exp_rd = 0;
      if (re) begin
         case (rs)
            2'd0: exp_rd = (al || sf == 0) ? 0 : int'(mfree[0]);
            2'd2: exp_rd = (sd == 0) ? 0 : int'(mdone[0]);
            2'd3: exp_rd = (sr == 0) ? 0 : int'(mrx[0]);
            default: exp_rd = 0;
         endcase
      end
      chk(tag, int'(host_rd_data), exp_rd);
      chk("R8 tx_head", int'(tx_head), (st == 0) ? 0 : int'(mtx[0]));
      chk("R8 tx_pending", int'(tx_pending), int'(st != 0));
      fv = (sf > 0) ? mfree[0] : 8'd0;
      @(posedge clk);
      if (al) void'(mfree.pop_front());
      else if (re && rs == 2'd0 && sf > 0) void'(mfree.pop_front());
      if (re && rs == 2'd2 && sd > 0) void'(mdone.pop_front());
      if (re && rs == 2'd3 && sr > 0) void'(mrx.pop_front());
      if (al) mrx.push_back(fv);
      if (we && ws == 2'd0 && wd != 0 && int'(wd) <= lastp && sf < DEPTH) mfree.push_back(wd);
      if (we && ws == 2'd1 && st < DEPTH) mtx.push_back(wd);
      if (tc && st > 0) begin
         void'(mtx.pop_front());
         if (sd < DEPTH) mdone.push_back(ts);
      end
      if (starve) m_rxd = 1'b1;
      else if (clr) m_rxd = 1'b0;
   endtask

   task automatic hpush(input logic [1:0] s, input logic [7:0] d, input string tag);
      step(1, s, d, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic hpop(input logic [1:0] s, input string tag);
      step(0, 0, 0, 1, s, 0, 0, 0, 0, tag);
   endtask
   task automatic rxreq(input string tag);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, tag);
   endtask
   task automatic txdone(input logic [7:0] s, input string tag);
      step(0, 0, 0, 0, 0, 0, 1, s, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 free_count", int'(free_count), 0);
      chk("R1 recv_count", int'(recv_count), 0);
      chk("R1 rx_disabled", int'(rx_disabled), 0);
      rst = 1'b0;
      #1;
      chk("R1 xmit_count", int'(xmit_count), 0);
      chk("R1 done_count", int'(done_count), 0);
      chk("R1 tx_pending", int'(tx_pending), 0);
      chk("R1 tx_head", int'(tx_head), 0);
      chk("R1 rx_not_empty", int'(rx_not_empty), 0);
      chk("R1 done_not_empty", int'(done_not_empty), 0);
      chk("R4 last_page small", int'(last_page), 63);
      mon_on = 1'b1;

      // R4: out-of-range pages are rejected by the free queue
      hpush(0, 8'd0, "R4");
      hpush(0, 8'd64, "R4");
      for (int p = 1; p <= 63; p++) hpush(0, 8'(p), "R2");

      // R2: order preserved, then recycle to the tail
      for (int i = 0; i < 3; i++) hpop(0, "R2");
      for (int p = 1; p <= 3; p++) hpush(0, 8'(p), "R2");

      // R5: receive allocations
      for (int i = 0; i < 5; i++) rxreq("R5");
      hpop(3, "R5");
      hpop(3, "R5");

      // R9: allocation and host free read collide
      step(0, 0, 0, 1, 0, 1, 0, 0, 0, "R9");
      // R9: writes to done/receive ignored, read of transmit select gives 0
      hpush(2, 8'd9, "R9");
      hpush(3, 8'd9, "R9");
      hpop(1, "R9");

      // R3: drain the free queue past empty
      for (int i = 0; i < 70; i++) hpop(0, "R3");

      // R7: starvation disables the receiver
      rxreq("R7");
      rxreq("R7");
      hpush(0, 8'd10, "R7");
      hpush(0, 8'd11, "R7");
      rxreq("R7");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
      rxreq("R7");
      for (int i = 0; i < 8; i++) hpop(3, "R6");

      // R8: transmit and completion
      hpush(1, 8'd5, "R8");
      hpush(1, 8'd6, "R8");
      hpush(1, 8'd7, "R8");
      txdone(8'h81, "R8");
      txdone(8'h3C, "R8");
      hpop(2, "R8");
      hpop(2, "R8");
      txdone(8'hF0, "R8");
      txdone(8'h11, "R8");
      hpop(2, "R8");
      hpop(2, "R3");

      // R3: full transmit and done queues
      for (int i = 0; i < 130; i++) hpush(1, 8'(i + 1), "R3");
      for (int i = 0; i < 130; i++) txdone(8'(i * 7 + 3), "R3");
      for (int i = 0; i < 130; i++) hpop(2, "R3");

      // R4: large memory setting
      @(negedge clk);
      mem_large = 1'b1;
      #1;
      chk("R4 last_page large", int'(last_page), 127);
      hpush(0, 8'd127, "R4");
      hpush(0, 8'd128, "R4");
      hpush(0, 8'd100, "R4");
      // R2: push and pop on the free queue in one cycle
      step(1, 0, 8'd50, 1, 0, 0, 0, 0, 0, "R2");
      for (int i = 0; i < 4; i++) hpop(0, "R2");

      @(negedge clk);
      summary();
      $finish;
   end
endmodule